// File: doc/BRIEF.md
# Ordered-Rank CFAR Detector with Threshold Fusion

This block is a streaming target detector for a one-dimensional stream of cell amplitudes, such as range or frequency bins after the spectrum stage of a radar receiver. It holds a sliding window of N+1 cells. The middle cell is the cell under test. The N cells around it, H on each side, are the reference cells. The block ranks the reference cells from smallest to largest and takes the k-th value as its noise estimate Z. It multiplies Z by a programmable fixed-point factor to form a threshold. The cell under test is flagged as a target when it is strictly larger than that threshold.

The ranking is not rebuilt from scratch for each sample. The block keeps one ascending register array that holds every cell of the window, the cell under test included. On each accepted sample it removes the value that leaves the window and inserts the value that arrives, in a single update. The k-th reference value is then read from this array, with one index adjustment that skips over the cell under test.

A fusion mode can also combine this test with an averaging threshold that is computed elsewhere and fed in on the same beat. In the AND mode the cell must beat both thresholds. In the OR mode it must beat either one. The reported threshold is the one that the decision actually used.

Top module: `rank_cfar_detector`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `det_vld`, `det_flag` and `det_thr` are 0. Every window cell resets to 0, so the first results compare against zero-valued history.
- R2: Beat j is the j-th cycle with `in_vld` high. On beat j the cell under test is the sample of beat j-H. The reference cells are the samples of beats j-2H..j-H-1 and j-H+1..j. The window is 2H+1 cells (N = 2H).
- R3: Z is the k-th smallest of the N reference cells, where k=1 is the smallest. The cell under test is excluded. Equal values count as separate entries, so duplicates enter and leave the ranking one at a time.
- R4: A `rank_k` of 0, or any value above N, is treated as N.
- R5: The ordered-rank threshold is Z times `alpha`. `alpha` is unsigned with FRAC fraction bits, so `det_thr` carries FRAC fraction bits in sample units.
- R6: `det_flag` is 1 only when the cell under test, scaled by 2^FRAC, is strictly greater than `det_thr`. Equality does not detect.
- R7: With `fuse_mode` = 2'b00, `det_thr` is the ordered-rank threshold alone.
- R8: With `fuse_mode` = 2'b01 (AND), `det_thr` is the larger of the ordered-rank threshold and `ca_thr`, so a detect needs both thresholds beaten.
- R9: With `fuse_mode` = 2'b10 (OR), `det_thr` is the smaller of the two, so beating either threshold is enough.
- R10: With `fuse_mode` = 2'b11, the block behaves as with 2'b00.
- R11: `ca_thr`, `rank_k`, `alpha` and `fuse_mode` are taken on the same beat as the sample. The result for that beat appears with `det_vld` high exactly two rising edges after the beat is presented.
- R12: A cycle with `in_vld` low neither shifts the window nor produces a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Sample beat valid |
| in_smp | input | DW | Incoming cell amplitude, unsigned |
| ca_thr | input | DW+SW | Averaging threshold for this beat's cell under test, FRAC fraction bits |
| rank_k | input | clog2(N+1) | Rank of the reference value used as noise estimate |
| alpha | input | SW | Threshold scale factor, FRAC fraction bits |
| fuse_mode | input | 2 | 00 rank only, 01 AND, 10 OR, 11 rank only |
| det_vld | output | 1 | Result valid |
| det_flag | output | 1 | Target declared |
| det_thr | output | DW+SW | Threshold used for the decision, FRAC fraction bits |

## Verification
The bench uses the defaults: H=4 (eight reference cells), 12-bit samples, and an 8-bit scale with 4 fraction bits. With H=4 the 4-bit rank field can carry 0 and 9..15, so the clamp to N is exercised. Every rank from 1 to 8 can also be swept across the windows. The narrow scale makes exact equality between the scaled cell and the threshold easy to produce, for example a factor of 1.0 over a flat run of equal samples. That run also fills the sorted array with duplicates, which tests one-copy removal. Idle gaps between beats test that the window holds and that the result timing stays fixed.

// File: rtl/rcfar_pkg.sv
package rcfar_pkg;
  typedef enum logic [1:0] {
    FUSE_RANK = 2'b00,
    FUSE_AND  = 2'b01,
    FUSE_OR   = 2'b10,
    FUSE_RSV  = 2'b11
  } fuse_e;
endpackage

// File: rtl/rcfar_window.sv
module rcfar_window #(
  parameter int DW = 12,
  parameter int H  = 4,
  localparam int M = 2 * H + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic [DW-1:0]        in_smp,
  output logic [M-1:0][DW-1:0] taps,
  output logic [DW-1:0]        cut,
  output logic [DW-1:0]        oldest
);
  // taps[0] newest, taps[M-1] oldest; centre cell is the cell under test
  always_ff @(posedge clk) begin
    if (rst) taps <= '0;
    else if (in_vld) taps <= {taps[M-2:0], in_smp};
  end

  assign cut    = taps[H];
  assign oldest = taps[M-1];

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(taps));
endmodule

// File: rtl/rcfar_sorter.sv
module rcfar_sorter #(
  parameter int DW = 12,
  parameter int H  = 4,
  localparam int M = 2 * H + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic [DW-1:0]        rm_val,
  input  logic [DW-1:0]        ins_val,
  output logic [M-1:0][DW-1:0] srt
);
  logic [M-1:0][DW-1:0] srt_q, nxt;
  logic [M-2:0][DW-1:0] cut_arr;  // array with one copy of rm_val removed
  logic [M-1:0]         le;

  // Removal: first entry equal to rm_val sits at count(srt < rm_val);
  // every entry from there on takes its upper neighbour.
  for (genvar j = 0; j < M - 1; j++) begin : g_rm
    assign cut_arr[j] = (srt_q[j] >= rm_val) ? srt_q[j+1] : srt_q[j];
    assign le[j]      = (cut_arr[j] <= ins_val);
  end
  assign le[M-1] = 1'b0;

  // Insertion after any equal entries: keeps equal values in a stable order
  for (genvar j = 0; j < M; j++) begin : g_ins
    if (j == 0) begin : g_first
      assign nxt[j] = le[0] ? cut_arr[0] : ins_val;
    end else if (j == M - 1) begin : g_last
      assign nxt[j] = le[M-2] ? ins_val : cut_arr[M-2];
    end else begin : g_mid
      assign nxt[j] = le[j]   ? cut_arr[j] :
                      le[j-1] ? ins_val    : cut_arr[j-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) srt_q <= '0;
    else if (in_vld) srt_q <= nxt;
  end

  assign srt = srt_q;

  for (genvar j = 0; j < M - 1; j++) begin : g_chk
    assert_sorted_R3: assert property (@(posedge clk) disable iff (rst)
      srt_q[j] <= srt_q[j+1]);
  end
endmodule

// File: rtl/rcfar_decide.sv
module rcfar_decide
  import rcfar_pkg::*;
#(
  parameter int DW   = 12,
  parameter int H    = 4,
  parameter int SW   = 8,
  parameter int FRAC = 4,
  localparam int M   = 2 * H + 1,
  localparam int N   = 2 * H,
  localparam int KW  = $clog2(N + 1),
  localparam int IW  = $clog2(M + 1),
  localparam int TW  = DW + SW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic [TW-1:0]        ca_thr,
  input  logic [KW-1:0]        rank_k,
  input  logic [SW-1:0]        alpha,
  input  logic [1:0]           fuse_mode,
  input  logic [DW-1:0]        cut,
  input  logic [M-1:0][DW-1:0] srt,
  output logic                 det_vld,
  output logic                 det_flag,
  output logic [TW-1:0]        det_thr
);
  // stage 1: controls captured alongside the sample beat
  logic          v1;
  logic [TW-1:0] ca_q;
  logic [KW-1:0] k_q;
  logic [SW-1:0] alpha_q;
  fuse_e         mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1      <= 1'b0;
      ca_q    <= '0;
      k_q     <= '0;
      alpha_q <= '0;
      mode_q  <= FUSE_RANK;
    end else begin
      v1 <= in_vld;
      if (in_vld) begin
        ca_q    <= ca_thr;
        k_q     <= rank_k;
        alpha_q <= alpha;
        mode_q  <= fuse_e'(fuse_mode);
      end
    end
  end

  // stage 2 combinational: rank select, scale, fuse
  logic [IW-1:0] below_cnt, keff, sel;
  logic [DW-1:0] z;
  logic [TW-1:0] os_thr, cut_fp, used_thr;
  logic          hit;

  always_comb begin
    below_cnt = '0;
    for (int i = 0; i < M; i++) begin
      below_cnt = below_cnt + IW'(srt[i] < cut);
    end
  end

  always_comb begin
    if (k_q == '0 || IW'(k_q) > IW'(N)) keff = IW'(N);
    else keff = IW'(k_q);
    // the CUT occupies slot below_cnt of the full sorted window
    sel = ((keff - IW'(1)) < below_cnt) ? (keff - IW'(1)) : keff;
    z   = srt[sel];
  end

  assign os_thr = TW'(z) * TW'(alpha_q);
  assign cut_fp = TW'({cut, {FRAC{1'b0}}});

  always_comb begin
    unique case (mode_q)
      FUSE_AND: used_thr = (os_thr > ca_q) ? os_thr : ca_q;
      FUSE_OR:  used_thr = (os_thr < ca_q) ? os_thr : ca_q;
      default:  used_thr = os_thr;
    endcase
    hit = cut_fp > used_thr;
  end

  // stage 2 registers
  logic          det_vld_q, det_flag_q;
  logic [TW-1:0] det_thr_q, os_r, ca_r, cutfp_r;
  fuse_e         mode_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      det_vld_q  <= 1'b0;
      det_flag_q <= 1'b0;
      det_thr_q  <= '0;
      os_r       <= '0;
      ca_r       <= '0;
      cutfp_r    <= '0;
      mode_r     <= FUSE_RANK;
    end else begin
      det_vld_q <= v1;
      if (v1) begin
        det_flag_q <= hit;
        det_thr_q  <= used_thr;
        os_r       <= os_thr;
        ca_r       <= ca_q;
        cutfp_r    <= cut_fp;
        mode_r     <= mode_q;
      end else begin
        det_flag_q <= 1'b0;
      end
    end
  end

  assign det_vld  = det_vld_q;
  assign det_flag = det_flag_q;
  assign det_thr  = det_thr_q;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!det_vld_q && !det_flag_q));
  assert_clamp_R4: assert property (@(posedge clk) disable iff (rst)
    v1 |-> (sel <= IW'(N)));
  assert_and_R8: assert property (@(posedge clk) disable iff (rst)
    (det_vld_q && det_flag_q && mode_r == FUSE_AND) |-> (cutfp_r > os_r && cutfp_r > ca_r));
  assert_or_R9: assert property (@(posedge clk) disable iff (rst)
    (det_vld_q && !det_flag_q && mode_r == FUSE_OR) |-> (cutfp_r <= os_r && cutfp_r <= ca_r));
  assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> ##1 det_vld_q);
endmodule

// File: rtl/rank_cfar_detector.sv
module rank_cfar_detector #(
  parameter int DW   = 12,
  parameter int H    = 4,
  parameter int SW   = 8,
  parameter int FRAC = 4,
  localparam int M   = 2 * H + 1,
  localparam int N   = 2 * H,
  localparam int KW  = $clog2(N + 1),
  localparam int TW  = DW + SW,
  localparam int SUMW = DW + $clog2(M) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [DW-1:0] in_smp,
  input  logic [TW-1:0] ca_thr,
  input  logic [KW-1:0] rank_k,
  input  logic [SW-1:0] alpha,
  input  logic [1:0]    fuse_mode,
  output logic          det_vld,
  output logic          det_flag,
  output logic [TW-1:0] det_thr
);
  logic [M-1:0][DW-1:0] taps, srt;
  logic [DW-1:0]        cut, oldest;

  rcfar_window #(.DW(DW), .H(H)) u_win (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_smp(in_smp),
    .taps(taps), .cut(cut), .oldest(oldest)
  );

  rcfar_sorter #(.DW(DW), .H(H)) u_sort (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .rm_val(oldest), .ins_val(in_smp), .srt(srt)
  );

  rcfar_decide #(.DW(DW), .H(H), .SW(SW), .FRAC(FRAC)) u_dec (
    .clk(clk), .rst(rst), .in_vld(in_vld), .ca_thr(ca_thr),
    .rank_k(rank_k), .alpha(alpha), .fuse_mode(fuse_mode),
    .cut(cut), .srt(srt),
    .det_vld(det_vld), .det_flag(det_flag), .det_thr(det_thr)
  );

  // the sorted array must always hold the same multiset as the window
  logic [SUMW-1:0] sum_taps, sum_srt;
  always_comb begin
    sum_taps = '0;
    sum_srt  = '0;
    for (int i = 0; i < M; i++) begin
      sum_taps = sum_taps + SUMW'(taps[i]);
      sum_srt  = sum_srt + SUMW'(srt[i]);
    end
  end

  assert_sum_R2: assert property (@(posedge clk) disable iff (rst)
    sum_taps == sum_srt);
endmodule

// File: tb/rank_cfar_detector_tb_top.sv
module rank_cfar_detector_tb_top;
  localparam int DW = 12, H = 4, SW = 8, FRAC = 4;
  localparam int N = 2 * H, TW = DW + SW, KW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_vld = 1'b0;
  logic [DW-1:0] in_smp = '0;
  logic [TW-1:0] ca_thr = '0;
  logic [KW-1:0] rank_k = '0;
  logic [SW-1:0] alpha = '0;
  logic [1:0]    fuse_mode = '0;
  logic          det_vld, det_flag;
  logic [TW-1:0] det_thr;

  rank_cfar_detector #(.DW(DW), .H(H), .SW(SW), .FRAC(FRAC)) dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_smp(in_smp), .ca_thr(ca_thr),
    .rank_k(rank_k), .alpha(alpha), .fuse_mode(fuse_mode),
    .det_vld(det_vld), .det_flag(det_flag), .det_thr(det_thr)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  int hist[$];
  bit    q_flag[$];
  int    q_thr[$];
  int    q_cyc[$];
  string q_req[$];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL R11 watchdog expired: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int val(int i);
    return (i < 0) ? 0 : hist[i];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: presents one beat and pushes its expected result
  task automatic beat(int x, int ca, int k, int a, int mode, string req);
    int r[N];
    int idx, j, cutv, ke, z, os, thr, tmp;
    @(negedge clk);
    in_vld = 1'b1; in_smp = DW'(x); ca_thr = TW'(ca);
    rank_k = KW'(k); alpha = SW'(a); fuse_mode = 2'(mode);
    hist.push_back(x);
    j = hist.size() - 1;
    cutv = val(j - H);
    idx = 0;
    for (int d = 0; d <= 2 * H; d++) if (d != H) begin r[idx] = val(j - d); idx++; end
    for (int p = 0; p < N; p++)
      for (int q = 0; q < N - 1 - p; q++)
        if (r[q] > r[q+1]) begin tmp = r[q]; r[q] = r[q+1]; r[q+1] = tmp; end
    ke = (k == 0 || k > N) ? N : k;
    z = r[ke-1];
    os = z * a;
    case (mode)
      1: thr = (os > ca) ? os : ca;
      2: thr = (os < ca) ? os : ca;
      default: thr = os;
    endcase
    q_flag.push_back((cutv * (1 << FRAC)) > thr);
    q_thr.push_back(thr);
    q_cyc.push_back(cyc);
    q_req.push_back(req);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  // monitor: pops and compares at negedges
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (det_vld) begin
        if (q_flag.size() == 0) check(0, "R12 spurious det_vld", 1, 0);
        else begin
          automatic bit    ef = q_flag.pop_front();
          automatic int    et = q_thr.pop_front();
          automatic int    ec = q_cyc.pop_front();
          automatic string rq = q_req.pop_front();
          check(cyc == ec + 2, "R11 result timing", cyc, ec + 2);
          check(det_flag == ef, {rq, " det_flag"}, int'(det_flag), int'(ef));
          check(int'(det_thr) == et, {rq, " det_thr"}, int'(det_thr), et);
        end
      end else if (q_cyc.size() != 0 && cyc > q_cyc[0] + 2) begin
        check(0, "R11 missing result", 0, 1);
        void'(q_flag.pop_front()); void'(q_thr.pop_front());
        void'(q_cyc.pop_front()); void'(q_req.pop_front());
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    check(det_vld == 1'b0, "R1 det_vld after reset", int'(det_vld), 0);
    check(det_flag == 1'b0, "R1 det_flag after reset", int'(det_flag), 0);
    check(det_thr == '0, "R1 det_thr after reset", int'(det_thr), 0);

    // R2 R5 R6 R7: rank-only over noise with two adjacent spikes
    for (int i = 0; i < 40; i++) begin
      int x;
      x = 20 + (i * 7) % 13;
      if (i == 15) x = 200;
      if (i == 16) x = 190;
      beat(x, 0, 6, 48, 0, "R7");
    end
    // R3 R4: sweep every rank, including clamped codes 0 and 9..15
    for (int k = 0; k < 16; k++)
      for (int i = 0; i < 6; i++)
        beat(10 + (i * 37 + k * 11) % 90, 0, k, 24,
             0, (k == 0 || k > N) ? "R4" : "R3");
    // R3 R6: duplicates, then equality at alpha 1.0 does not detect
    for (int i = 0; i < 14; i++) beat(30, 0, 3, 16, 0, "R6");
    beat(31, 0, 5, 16, 0, "R3");
    for (int i = 0; i < 6; i++) beat(30, 0, 5, 16, 0, "R6");
    // R8 AND fusion with varying averaging thresholds
    for (int i = 0; i < 30; i++)
      beat((i % 5 == 0) ? 150 : 25 + i % 7, (i % 3) * 900 + 300, 4, 40, 1, "R8");
    // R9 OR fusion
    for (int i = 0; i < 30; i++)
      beat((i % 4 == 0) ? 90 : 25 + i % 6, (i % 3) * 700 + 200, 7, 64, 2, "R9");
    // R10 reserved code
    for (int i = 0; i < 16; i++)
      beat((i == 8) ? 120 : 40 + i % 3, 5, 2, 32, 3, "R10");
    // R12: idle gaps must not move the window
    for (int i = 0; i < 20; i++) begin
      beat((i == 10) ? 180 : 50 + (i * 3) % 11, 1000, 5, 40, i % 3, "R12");
      idle(1 + i % 3);
    end
    idle(6);
    check(q_flag.size() == 0, "R11 queue drained", q_flag.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule